// File: doc/BRIEF.md
# Stepped-Duty PWM Generator

This block drives a pulse-width-modulated output with a fixed period of 100 clock ticks. Each period starts with a high phase (the pulse) and ends with a low phase (the pause). The two lengths always add up to the period. Two single-bit request lines change the duty. One request widens the pulse by two ticks and the other narrows it by two ticks. Each request is taken on its rising edge, so holding a line high gives exactly one step.

A request never changes the period that is currently running. It only updates a pending copy of the pulse and pause lengths. That copy moves into the active lengths at the moment the in-cycle counter wraps from 99 to 0. The active pulse length is also presented as the block's current duty value. Every storage element is a flip-flop on the rising clock edge, and there are no level-sensitive holding elements. The block fits behind a debounced pair of push buttons or any other source of clean single-bit step requests.

Top module: `duty_stepped_pwm`

## Requirements
- R1: While reset is held, and after it is released, the active and pending pulse lengths are 10 and the pause lengths are 90, so `duty_now` reads 10.
- R2: The in-cycle counter counts 0 to 99 and wraps to 0. `pwm_out` is 1 exactly while the counter is below the active pulse length, which gives `duty_now` high ticks in every window of 100 consecutive ticks.
- R3: A rising edge on `up_req` adds 2 to the pending pulse length and takes 2 from the pending pause length.
- R4: A rising edge on `down_req` takes 2 from the pending pulse length and adds 2 to the pending pause length.
- R5: When both request lines rise in the same cycle, only the widening step is applied.
- R6: One rising edge gives exactly one step of 2, however many cycles the request line stays high.
- R7: A widening request is ignored when the pending pulse is already above 98. A narrowing request is ignored when the pending pulse is below 2. The pulse length therefore stays within 0 to 100.
- R8: The pending lengths are copied to the active lengths only on the clock edge where the counter wraps from 99 to 0. `duty_now` and `pwm_out` keep the old length until that edge.
- R9: With a pulse length of 0, `pwm_out` is low for the whole period. With a pulse length of 100, it is high for the whole period.
- R10: The pending pulse and pause lengths always sum to 100, and so do the active ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Widen-pulse request; a rising edge gives one step |
| down_req | input | 1 | Narrow-pulse request; a rising edge gives one step |
| pwm_out | output | 1 | PWM waveform |
| duty_now | output | 7 | Active pulse length in ticks (0 to 100) |

## Verification
The duty is driven through single-cycle presses, long held presses, simultaneous presses of both lines, and long runs of presses in one direction that reach each limit. These patterns separate a level-sensitive step from an edge-triggered one, the widening-first priority from the opposite order, and clamping from wrap-around. After each pattern, the high ticks are counted over a full 100-tick window and compared with `duty_now`, which shows whether the output compare and the counter agree. A press placed in the middle of a period, with the output watched on both sides of the wrap, shows whether the new length is held back to the cycle boundary.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

   // Step decision taken by the pending-length logic in one cycle
   typedef enum logic [1:0] {
      REQ_NONE = 2'd0,
      REQ_UP   = 2'd1,
      REQ_DOWN = 2'd2
   } req_kind_e;

   // Request input treatment: one-shot on rising edge, or a step every cycle while high
   localparam int unsigned EDGE_ONESHOT = 1;
   localparam int unsigned EDGE_LEVEL   = 0;

endpackage

// File: rtl/req_edge.sv
module req_edge #(
   parameter int unsigned MODE = pwm_duty_pkg::EDGE_ONESHOT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic evt
);
   if (MODE != pwm_duty_pkg::EDGE_ONESHOT && MODE != pwm_duty_pkg::EDGE_LEVEL) begin : g_bad_mode
      $error("req_edge: unsupported MODE");
   end

   if (MODE == pwm_duty_pkg::EDGE_ONESHOT) begin : g_oneshot
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= req;
      end
      assign evt = req & ~req_q;

      // One press yields at most one event in consecutive cycles
      p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
         evt |=> !evt);
   end else begin : g_level
      assign evt = req;
   end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
   parameter int unsigned PERIOD = 100,
   parameter int unsigned CNT_W  = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("cycle_timer: PERIOD must be at least 2");
   end
   if ((2 ** CNT_W) < PERIOD) begin : g_bad_width
      $error("cycle_timer: CNT_W too narrow for PERIOD");
   end

   assign wrap = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST) |=> (cnt == '0));
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/duty_shadow.sv
module duty_shadow
   import pwm_duty_pkg::*;
#(
   parameter int unsigned PERIOD     = 100,
   parameter int unsigned LEN_W      = 7,
   parameter int unsigned STEP       = 2,
   parameter int unsigned INIT_PULSE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_evt,
   input  logic             dn_evt,
   input  logic             wrap,
   output logic [LEN_W-1:0] act_pulse,
   output logic [LEN_W-1:0] act_pause
);
   localparam logic [LEN_W-1:0] STEP_L   = LEN_W'(STEP);
   localparam logic [LEN_W-1:0] UP_MAX   = LEN_W'(PERIOD - STEP);
   localparam logic [LEN_W-1:0] RST_PULS = LEN_W'(INIT_PULSE);
   localparam logic [LEN_W-1:0] RST_PAUS = LEN_W'(PERIOD - INIT_PULSE);
   localparam logic [LEN_W:0]   SUM_L    = (LEN_W+1)'(PERIOD);

   if (STEP == 0 || STEP > PERIOD) begin : g_bad_step
      $error("duty_shadow: STEP out of range");
   end
   if (INIT_PULSE > PERIOD) begin : g_bad_init
      $error("duty_shadow: INIT_PULSE above PERIOD");
   end
   if (PERIOD >= (2 ** LEN_W)) begin : g_bad_len
      $error("duty_shadow: LEN_W cannot hold PERIOD");
   end

   logic [LEN_W-1:0] pend_pulse, pend_pause;
   logic [LEN_W-1:0] nxt_pulse, nxt_pause;
   req_kind_e        kind;

   // Widening wins; a request beyond the limit is dropped, not clamped
   always_comb begin
      kind = REQ_NONE;
      if (up_evt) begin
         if (pend_pulse <= UP_MAX) kind = REQ_UP;
      end else if (dn_evt) begin
         if (pend_pulse >= STEP_L) kind = REQ_DOWN;
      end
   end

   always_comb begin
      nxt_pulse = pend_pulse;
      nxt_pause = pend_pause;
      case (kind)
         REQ_UP: begin
            nxt_pulse = pend_pulse + STEP_L;
            nxt_pause = pend_pause - STEP_L;
         end
         REQ_DOWN: begin
            nxt_pulse = pend_pulse - STEP_L;
            nxt_pause = pend_pause + STEP_L;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_pulse <= RST_PULS;
         pend_pause <= RST_PAUS;
      end else begin
         pend_pulse <= nxt_pulse;
         pend_pause <= nxt_pause;
      end
   end

   // Active pair loads the pending pair (as held before this edge) at wrap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pulse <= RST_PULS;
         act_pause <= RST_PAUS;
      end else if (wrap) begin
         act_pulse <= pend_pulse;
         act_pause <= pend_pause;
      end
   end

   p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == REQ_UP) |=> (pend_pulse == $past(pend_pulse) + STEP_L));
   p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == REQ_DOWN) |=> (pend_pulse == $past(pend_pulse) - STEP_L));
   p_up_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_evt && dn_evt) |=> (pend_pulse >= $past(pend_pulse)));
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_pulse <= LEN_W'(PERIOD));
   p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_pulse));
   p_pend_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, pend_pulse} + {1'b0, pend_pause}) == SUM_L);
   p_act_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, act_pulse} + {1'b0, act_pause}) == SUM_L);
endmodule

// File: rtl/duty_stepped_pwm.sv
module duty_stepped_pwm
   import pwm_duty_pkg::*;
#(
   parameter int unsigned PERIOD     = 100,
   parameter int unsigned LEN_W      = 7,
   parameter int unsigned STEP       = 2,
   parameter int unsigned INIT_PULSE = 10,
   parameter int unsigned REQ_MODE   = EDGE_ONESHOT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_req,
   input  logic             down_req,
   output logic             pwm_out,
   output logic [LEN_W-1:0] duty_now
);
   localparam int unsigned CNT_W = $clog2(PERIOD);
   localparam int unsigned N_REQ = 2;

   if (CNT_W > LEN_W) begin : g_bad_cnt
      $error("duty_stepped_pwm: counter wider than length field");
   end

   logic [N_REQ-1:0] req_vec, evt_vec;
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic [LEN_W-1:0] act_pulse, act_pause;

   assign req_vec = {down_req, up_req};

   for (genvar i = 0; i < N_REQ; i++) begin : g_req
      req_edge #(.MODE(REQ_MODE)) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req_vec[i]),
         .evt   (evt_vec[i])
      );
   end

   cycle_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   duty_shadow #(
      .PERIOD     (PERIOD),
      .LEN_W      (LEN_W),
      .STEP       (STEP),
      .INIT_PULSE (INIT_PULSE)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_evt    (evt_vec[0]),
      .dn_evt    (evt_vec[1]),
      .wrap      (wrap),
      .act_pulse (act_pulse),
      .act_pause (act_pause)
   );

   assign pwm_out  = (LEN_W'(cnt) < act_pulse);
   assign duty_now = act_pulse;

   p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_pulse == '0) |-> !pwm_out);
   p_full_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_pulse == LEN_W'(PERIOD)) |-> pwm_out);
   p_pause_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && act_pause != '0) |-> !pwm_out);
endmodule

// File: tb/sim_duty_stepped_pwm.sv
`timescale 1ns/1ps
module sim_duty_stepped_pwm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up_req = 1'b0;
   logic       down_req = 1'b0;
   logic       pwm_out;
   logic [6:0] duty_now;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   duty_stepped_pwm u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_req   (up_req),
      .down_req (down_req),
      .pwm_out  (pwm_out),
      .duty_now (duty_now)
   );

   // op: 1 widen, 2 narrow, 3 both; presses; hold cycles; expected duty
   localparam int VEC [0:8][0:3] = '{
      '{1,  1,  1,  12},   // R3 single widen
      '{1,  1, 20,  14},   // R6 long hold, one step
      '{2,  3,  2,   8},   // R4 narrow x3
      '{3,  2,  1,  12},   // R5 both: widen wins
      '{2,  6,  1,   0},   // R4 down to zero, R9 low
      '{2,  1,  1,   0},   // R7 lower limit ignored
      '{1, 50,  1, 100},   // R3 up to full, R9 high
      '{1,  1,  3, 100},   // R7 upper limit ignored
      '{2,  1,  1,  98}    // R4 step back from full
   };

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic press(input int op, input int hold);
      up_req   = op[0];
      down_req = op[1];
      repeat (hold) @(negedge clk);
      up_req   = 1'b0;
      down_req = 1'b0;
      @(negedge clk);
   endtask

   // High ticks over any 100 consecutive ticks in steady state
   task automatic high_count(output int n);
      n = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (pwm_out) n++;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int prev;
      repeat (3) @(negedge clk);
      chk("R1 duty during reset", duty_now, 10);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 duty after reset", duty_now, 10);
      high_count(n);
      chk("R2 high ticks after reset", n, 10);

      foreach (VEC[v]) begin
         for (int p = 0; p < VEC[v][1]; p++) press(VEC[v][0], VEC[v][2]);
         repeat (200) @(negedge clk);
         chk($sformatf("R3/R4/R5/R6/R7 vector %0d duty", v), duty_now, VEC[v][3]);
         high_count(n);
         chk($sformatf("R2/R9 vector %0d high ticks", v), n, VEC[v][3]);
      end

      // R8: mid-cycle press deferred to the wrap; duty is 98 here
      prev = 1;
      forever begin
         @(negedge clk);
         if (!prev && pwm_out) break;
         prev = pwm_out;
      end
      // now counter is 0; each later negedge advances it by one
      repeat (40) @(negedge clk);
      up_req = 1'b1;
      @(negedge clk);
      up_req = 1'b0;
      repeat (56) @(negedge clk);            // counter 97
      chk("R2 high at tick 97", int'(pwm_out), 1);
      chk("R8 duty held mid-cycle", duty_now, 98);
      @(negedge clk);                         // counter 98
      chk("R2 low at tick 98", int'(pwm_out), 0);
      @(negedge clk);                         // counter 99
      chk("R8 duty held until wrap", duty_now, 98);
      @(negedge clk);                         // counter 0, loaded
      chk("R8 duty after wrap", duty_now, 100);
      high_count(n);
      chk("R9 full duty high ticks", n, 100);

      // R1: reset in mid-run restores the start values
      press(1, 1);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 duty after mid-run reset", duty_now, 10);
      high_count(n);
      chk("R10 pulse after reset gives pause 90", 100 - n, 90);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule